// File: doc/BRIEF.md
# Serial Interrupt Slot Encoder

This block is the peripheral end of a serialized interrupt link. Several host interrupt requests share one open-drain line, and the line runs on the 33 MHz bus clock. Three mailbox channels raise level requests. The first channel can raise IRQ1 and IRQ12. The second and third channels can each raise SMI, IRQ6, IRQ9, IRQ10 and IRQ11. The block merges these requests into one vector of serial slots. In each frame it signals every active slot inside that slot's own three-clock window.

A frame opens with a start pulse, in which the line is held low for four to eight clocks. A fixed run of three-clock data slots follows, and the frame closes with a stop pulse. The length of the stop pulse sets the mode for the frames that follow. In continuous mode the block only answers frames that the host opens. In quiet mode the block may also open a frame itself. It does this by pulling the line low for a single clock when its request levels differ from the levels it last reported. The host then extends that low clock into a full start pulse.

The line is modelled as an enable and a data value for an external tri-state buffer. The resolved line level comes back in as an input.

Top module: `serirq_slave`

## Requirements
- R1: While reset is held, and after it is released until a frame begins, the line enable is low and the mode is continuous.
- R2: When the line is seen high after a low run of START_MIN (4) to START_MAX (8) clocks while idle, a frame starts. Slot 0 occupies the three clocks right after the clock in which the high level was sampled, and slot k begins 3k clocks later.
- R3: A low run of fewer than 4 or more than 8 clocks while idle starts no frame, and no slot is driven afterwards.
- R4: In a slot whose request is set, the block drives low in the first clock, drives high in the second clock, and releases the line in the third clock.
- R5: In a slot whose request is clear, the line is never driven.
- R6: Slot mapping. ch1_req[0] (IRQ1) maps to slot 1 and ch1_req[1] (IRQ12) to slot 12. For channels 2 and 3, bit 0 (SMI) maps to slot 2, bit 1 (IRQ6) to slot 6, bit 2 (IRQ9) to slot 9, bit 3 (IRQ10) to slot 10 and bit 4 (IRQ11) to slot 11.
- R7: Channels 2 and 3 feed the same slots, and a slot is set when either channel's bit for it is set.
- R8: The slot vector is captured in the cycle the start is detected. Request changes during a frame take effect only in a later frame.
- R9: A stop pulse of 2 low clocks selects quiet mode. A stop pulse of 3 or more low clocks selects continuous mode.
- R10: In quiet mode, while idle with the line high, the block drives the line low for exactly one clock when the current slot vector differs from the one captured at the last frame start. It does this at most once until the next frame starts.
- R11: In continuous mode the block never opens a frame itself.
- R12: A frame has NUM_SLOTS (17) slots. After the last slot the block waits for the stop pulse and never drives during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sirq_in | input | 1 | Resolved level of the shared line |
| ch1_req | input | 2 | Channel 1 levels: bit 0 IRQ1, bit 1 IRQ12 |
| ch2_req | input | 5 | Channel 2 levels: SMI, IRQ6, IRQ9, IRQ10, IRQ11 (bits 0 to 4) |
| ch3_req | input | 5 | Channel 3 levels, same layout as channel 2 |
| sirq_oe | output | 1 | Drive enable for the line buffer |
| sirq_out | output | 1 | Value driven when enabled |

## Verification
The assertions assume that the host never drives the line while the block drives it, and that request levels only change between clock edges. The bench resolves the line so that the block's drive always takes precedence over the host. It changes requests and host drive a short delay after an edge, or at a falling edge. It holds start pulses to lengths the host would legally use, except for the deliberate 3-clock and 9-clock pulses. Host-side low drive is applied only during start and stop pulses, never inside the slot window.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

    localparam int CH1_SRC    = 2;
    localparam int SHARED_SRC = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KICK = 2'd1,
        ST_SLOT = 2'd2,
        ST_STOP = 2'd3
    } frame_st_t;

    typedef enum logic {
        MODE_CONT  = 1'b0,
        MODE_QUIET = 1'b1
    } sirq_mode_t;

    typedef struct packed {
        logic en;
        logic lvl;
    } pin_drive_t;

    // Slot number of a channel-1 source bit.
    function automatic int ch1_slot(input int idx);
        return (idx == 0) ? 1 : 12;
    endfunction

    // Slot number of a source bit shared by channels 2 and 3.
    function automatic int shared_slot(input int idx);
        case (idx)
            0:       return 2;
            1:       return 6;
            default: return 7 + idx;
        endcase
    endfunction

endpackage

// File: rtl/serirq_req_map.sv
module serirq_req_map
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS = 17
) (
    input  logic [CH1_SRC-1:0]    ch1_req,
    input  logic [SHARED_SRC-1:0] ch2_req,
    input  logic [SHARED_SRC-1:0] ch3_req,
    output logic [NUM_SLOTS-1:0]  slot_vec
);

    logic [SHARED_SRC-1:0] shared_lvl;

    for (genvar g = 0; g < SHARED_SRC; g++) begin : g_merge
        assign shared_lvl[g] = ch2_req[g] | ch3_req[g];
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < CH1_SRC; i++) begin
                if (ch1_slot(i) == s) hit = hit | ch1_req[i];
            end
            for (int j = 0; j < SHARED_SRC; j++) begin
                if (shared_slot(j) == s) hit = hit | shared_lvl[j];
            end
        end
        assign slot_vec[s] = hit;
    end

endmodule

// File: rtl/serirq_frame_ctl.sv
module serirq_frame_ctl
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS     = 17,
    parameter int START_MIN     = 4,
    parameter int START_MAX     = 8,
    parameter int STOP_CONT_LEN = 3,
    localparam int SLOT_W       = $clog2(NUM_SLOTS),
    localparam int CNT_W        = $clog2(START_MAX + 2)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_in,
    input  logic [NUM_SLOTS-1:0] req_vec,
    output frame_st_t            state,
    output logic [SLOT_W-1:0]    slot,
    output logic [1:0]           phase,
    output logic [NUM_SLOTS-1:0] snap,
    output sirq_mode_t           mode
);

    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [CNT_W-1:0]     low_cnt;
    logic [NUM_SLOTS-1:0] sent;
    logic                 kicked;
    logic                 start_ok;
    logic                 kick_ok;
    logic [CNT_W-1:0]     low_inc;

    assign low_inc  = (low_cnt == CNT_MAX) ? CNT_MAX : low_cnt + 1'b1;
    assign start_ok = (low_cnt >= CNT_W'(START_MIN)) && (low_cnt <= CNT_W'(START_MAX));
    assign kick_ok  = (mode == MODE_QUIET) && (low_cnt == '0) && !kicked
                      && (req_vec != sent);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            low_cnt <= '0;
            slot    <= '0;
            phase   <= 2'd0;
            snap    <= '0;
            sent    <= '0;
            kicked  <= 1'b0;
            mode    <= MODE_CONT;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!line_in) begin
                        low_cnt <= low_inc;
                    end else begin
                        low_cnt <= '0;
                        if (start_ok) begin
                            state  <= ST_SLOT;
                            slot   <= '0;
                            phase  <= 2'd0;
                            snap   <= req_vec;
                            sent   <= req_vec;
                            kicked <= 1'b0;
                        end else if (kick_ok) begin
                            state  <= ST_KICK;
                            kicked <= 1'b1;
                        end
                    end
                end
                ST_KICK: begin
                    state   <= ST_IDLE;
                    low_cnt <= line_in ? '0 : CNT_W'(1);
                end
                ST_SLOT: begin
                    if (phase == 2'd2) begin
                        phase <= 2'd0;
                        if (slot == LAST_SLOT) begin
                            state   <= ST_STOP;
                            low_cnt <= '0;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end else begin
                        phase <= phase + 2'd1;
                    end
                end
                ST_STOP: begin
                    if (!line_in) begin
                        low_cnt <= low_inc;
                    end else if (low_cnt != '0) begin
                        mode    <= (low_cnt >= CNT_W'(STOP_CONT_LEN)) ? MODE_CONT : MODE_QUIET;
                        state   <= ST_IDLE;
                        low_cnt <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2 / R3: a frame opens only after a legal low run
    assert_start_len_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT && $past(state) == ST_IDLE) |->
            ($past(low_cnt) >= CNT_W'(START_MIN) && $past(low_cnt) <= CNT_W'(START_MAX)));

    // R8: captured vector holds still for the whole frame
    assert_snap_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT && $past(state) == ST_SLOT) |-> $stable(snap));

    // R11: self-start only happens in quiet mode
    assert_cont_no_kick_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_KICK) |-> (mode == MODE_QUIET));

    // R10: self-start lasts one clock
    assert_kick_one_clock_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_KICK) |=> (state == ST_IDLE));

endmodule

// File: rtl/serirq_slot_drv.sv
module serirq_slot_drv
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS = 17,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  frame_st_t            state,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [1:0]           phase,
    input  logic [NUM_SLOTS-1:0] snap,
    output pin_drive_t           drive
);

    logic slot_active;

    assign slot_active = (state == ST_SLOT) && snap[slot];

    always_comb begin
        drive.en  = 1'b0;
        drive.lvl = 1'b0;
        case (state)
            ST_KICK: drive.en = 1'b1;
            ST_SLOT: begin
                drive.en  = slot_active && (phase != 2'd2);
                drive.lvl = (phase == 2'd1);
            end
            default: drive.en = 1'b0;
        endcase
    end

endmodule

// File: rtl/serirq_slave.sv
module serirq_slave
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS     = 17,
    parameter int START_MIN     = 4,
    parameter int START_MAX     = 8,
    parameter int STOP_CONT_LEN = 3,
    localparam int SLOT_W       = $clog2(NUM_SLOTS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sirq_in,
    input  logic [1:0] ch1_req,
    input  logic [4:0] ch2_req,
    input  logic [4:0] ch3_req,
    output logic       sirq_oe,
    output logic       sirq_out
);

    logic [NUM_SLOTS-1:0] req_vec;
    logic [NUM_SLOTS-1:0] snap;
    frame_st_t            state;
    logic [SLOT_W-1:0]    slot;
    logic [1:0]           phase;
    sirq_mode_t           mode;
    pin_drive_t           drive;

    serirq_req_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .ch1_req  (ch1_req),
        .ch2_req  (ch2_req),
        .ch3_req  (ch3_req),
        .slot_vec (req_vec)
    );

    serirq_frame_ctl #(
        .NUM_SLOTS     (NUM_SLOTS),
        .START_MIN     (START_MIN),
        .START_MAX     (START_MAX),
        .STOP_CONT_LEN (STOP_CONT_LEN)
    ) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .line_in (sirq_in),
        .req_vec (req_vec),
        .state   (state),
        .slot    (slot),
        .phase   (phase),
        .snap    (snap),
        .mode    (mode)
    );

    serirq_slot_drv #(.NUM_SLOTS(NUM_SLOTS)) u_drv (
        .state (state),
        .slot  (slot),
        .phase (phase),
        .snap  (snap),
        .drive (drive)
    );

    assign sirq_oe  = drive.en;
    assign sirq_out = drive.lvl;

    // R4: a low slot clock is followed by a high clock
    assert_low_then_high_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT && sirq_oe && !sirq_out) |=> (sirq_oe && sirq_out));

    // R4: a high clock is followed by release
    assert_high_then_release_R4: assert property (@(posedge clk) disable iff (rst)
        (sirq_oe && sirq_out) |=> !sirq_oe);

    // R12: nothing is driven while the stop pulse is awaited
    assert_stop_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> !sirq_oe);

    // R1: reset leaves the line released in the next cycle
    assert_reset_release_R1: assert property (@(posedge clk)
        rst |=> !sirq_oe);

endmodule

// File: tb/tb_serirq_slave.sv
`timescale 1ns/1ps
module tb_serirq_slave;

    localparam int N = 17;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       drv_low = 1'b0;
    logic [1:0] ch1_req = '0;
    logic [4:0] ch2_req = '0;
    logic [4:0] ch3_req = '0;
    logic       dut_oe, dut_out, sirq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    assign sirq = dut_oe ? dut_out : ~drv_low;

    always #2 clk = ~clk;

    serirq_slave dut (
        .clk(clk), .rst(rst), .sirq_in(sirq),
        .ch1_req(ch1_req), .ch2_req(ch2_req), .ch3_req(ch3_req),
        .sirq_oe(dut_oe), .sirq_out(dut_out)
    );

    function automatic logic [N-1:0] ref_vec(input logic [1:0] a, input logic [4:0] b,
                                             input logic [4:0] c);
        logic [N-1:0] v = '0;
        v[1] = a[0]; v[12] = a[1];
        v[2] = b[0] | c[0]; v[6] = b[1] | c[1];
        v[9] = b[2] | c[2]; v[10] = b[3] | c[3]; v[11] = b[4] | c[4];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference: time-in-frame counter, no slot/phase registers
    int           m_st;   // 0 idle, 1 self-start, 2 frame, 3 stop
    int           m_low, m_t;
    bit           m_quiet, m_kicked;
    logic [N-1:0] m_snap, m_sent, m_now;
    bit           e_oe, e_out;

    always @(posedge clk) begin
        m_now = ref_vec(ch1_req, ch2_req, ch3_req);
        if (rst) begin
            m_st = 0; m_low = 0; m_t = 0; m_quiet = 0; m_kicked = 0;
            m_snap = '0; m_sent = '0;
        end else begin
            case (m_st)
                0: if (!sirq) m_low = (m_low < 15) ? m_low + 1 : 15;
                   else begin
                       if (m_low >= 4 && m_low <= 8) begin
                           m_st = 2; m_t = 0; m_snap = m_now; m_sent = m_now; m_kicked = 0;
                       end else if (m_low == 0 && m_quiet && !m_kicked && m_now != m_sent) begin
                           m_st = 1; m_kicked = 1;
                       end
                       m_low = 0;
                   end
                1: begin m_st = 0; m_low = sirq ? 0 : 1; end
                2: begin m_t++; if (m_t == 3 * N) begin m_st = 3; m_low = 0; end end
                default: if (!sirq) m_low++;
                         else if (m_low > 0) begin m_quiet = (m_low < 3); m_st = 0; m_low = 0; end
            endcase
        end
        e_oe  = (m_st == 1) || (m_st == 2 && m_snap[m_t / 3] && (m_t % 3) != 2);
        e_out = (m_st == 2) && (m_t % 3 == 1);
    end

    always @(negedge clk) begin
        if (!rst) begin
            string tag;
            tag = (m_st == 1) ? "R10" : (e_oe ? "R4" : "R5");
            chk(dut_oe == e_oe && (!e_oe || dut_out == e_out), tag,
                {dut_oe, dut_out}, {e_oe, e_out});
        end
    end

    task automatic start_pulse(input int n);
        drv_low = 1'b1;
        repeat (n) @(posedge clk);
        #1 drv_low = 1'b0;
    endtask

    task automatic capture(input logic [N-1:0] expv, input string tag, input int chg_at);
        logic [N-1:0] good = '0, stray = '0;
        bit p0 = 0, p1 = 0;
        @(posedge clk);
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            case (i % 3)
                0: p0 = dut_oe && !dut_out;
                1: p1 = dut_oe && dut_out;
                default: begin
                    good[i / 3] = p0 && p1 && !dut_oe;
                    stray[i / 3] = !(p0 && p1) && (p0 || p1 || dut_oe);
                end
            endcase
            if (i == chg_at) ch1_req = 2'b11;
        end
        chk(good == expv, tag, good, expv);
        chk(stray == '0, {tag, " R5"}, stray, 0);
    endtask

    task automatic stop_pulse(input int m);
        bit bad = 0;
        @(posedge clk);
        #1 drv_low = 1'b1;
        for (int i = 0; i < m; i++) begin
            @(negedge clk);
            if (dut_oe) bad = 1;
            @(posedge clk);
        end
        #1 drv_low = 1'b0;
        chk(!bad, "R12 drive during stop", bad, 0);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic quiet_window(input int n, input string tag);
        bit bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (dut_oe) bad = 1;
        end
        @(posedge clk);
        #1;
        chk(!bad, tag, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen;
        @(negedge clk);
        chk(!dut_oe, "R1 oe in reset", dut_oe, 0);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: released and continuous (no self-start on request change)
        ch1_req = 2'b01;
        quiet_window(10, "R1 idle after reset");

        // R3: too short and too long start pulses
        start_pulse(3);
        quiet_window(60, "R3 three-clock pulse");
        start_pulse(9);
        quiet_window(60, "R3 nine-clock pulse");

        // R2 R6: minimum start, IRQ1 and SMI
        ch2_req = 5'b00001;
        start_pulse(4);
        capture(ref_vec(ch1_req, ch2_req, ch3_req), "R2 R6 slots 1,2", -1);
        stop_pulse(3);

        // R6 R7: maximum start, OR of channels 2 and 3
        ch1_req = 2'b10; ch2_req = 5'b00010; ch3_req = 5'b10010;
        start_pulse(8);
        capture((N'(1) << 6) | (N'(1) << 11) | (N'(1) << 12), "R6 R7 slots 6,11,12", -1);
        stop_pulse(3);

        // R8: change mid-frame is deferred
        ch1_req = 2'b01; ch2_req = '0; ch3_req = '0;
        start_pulse(5);
        capture(N'(1) << 1, "R8 snapshot held", 3);
        stop_pulse(3);
        start_pulse(6);
        capture((N'(1) << 1) | (N'(1) << 12), "R8 next frame", -1);
        stop_pulse(2);

        // R9 R10: quiet mode self-start on change
        ch2_req = 5'b00100;
        seen = 0;
        for (int i = 0; i < 6 && !seen; i++) begin
            @(negedge clk);
            if (dut_oe && !dut_out) seen = 1;
        end
        chk(seen, "R9 R10 self-start", seen, 1);
        @(posedge clk);
        #1 drv_low = 1'b1;
        repeat (3) @(posedge clk);
        #1 drv_low = 1'b0;
        capture((N'(1) << 1) | (N'(1) << 9) | (N'(1) << 12), "R10 frame after self-start", -1);
        stop_pulse(2);
        quiet_window(20, "R10 no repeat without change");

        // R9 R11: back to continuous, no self-start
        start_pulse(4);
        capture((N'(1) << 1) | (N'(1) << 9) | (N'(1) << 12), "R12 frame length", -1);
        stop_pulse(3);
        ch3_req = 5'b01000;
        quiet_window(30, "R9 R11 continuous no self-start");
        start_pulse(7);
        capture((N'(1) << 1) | (N'(1) << 9) | (N'(1) << 10) | (N'(1) << 12), "R7 R11 host frame", -1);
        stop_pulse(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule